// File: doc/BRIEF.md
# Receive Frame Header Screener

This block sorts received Ethernet frames into receive queues. It reads two header fields as the frame streams in: the differentiated-services / traffic-class byte of the IPv4 header and the UDP destination port. It compares them against a small bank of programmable screening rules. Frame bytes arrive one per cycle when `in_valid` is high. `in_sof` marks the first destination-MAC byte and `in_eof` marks the last byte of the frame.

Each rule holds a target queue, a drop request, a DS/TC value and a port value, and it can enable either comparison on its own. A rule selects the frame when at least one of its enabled comparisons matched and none of its enabled comparisons failed. Rules are tried in ascending index order and the lowest-indexed rule that selects the frame decides the result. The result is a queue number and a drop flag, marked by a single-cycle `res_valid` pulse. It appears as soon as the port bytes have passed, or at end of frame for a frame that is too short to carry them.

Rules are programmed through an index/data/write-enable port into a staging copy. The staging copy is moved into the working copy on each start of frame, so a frame is always judged against one consistent rule set.

Top module: `rx_screen_classifier`

## Requirements
- R1: After reset `res_valid` is low and every rule is disabled, so a frame sent before any write is given queue 0 with drop clear.
- R2: A rule word places the queue number in bits 3:0, the DS/TC value in bits 11:4 and the port value in bits 27:12. Bit 28 enables the DS/TC comparison, bit 29 enables the port comparison and bit 30 requests drop. Bit 31 is ignored.
- R3: The DS/TC byte is frame byte 15, counted from 0 at the `in_sof` byte. The port is big-endian, with byte 36 as the high byte and byte 37 as the low byte.
- R4: A rule selects the frame only if at least one enabled comparison matched and no enabled comparison mismatched. With both comparisons enabled, one mismatch rejects the rule.
- R5: A rule with neither comparison enabled never selects a frame, whatever its other fields hold.
- R6: When several rules select the frame, the rule with the lowest index wins.
- R7: When no rule selects the frame, the result is queue 0 with drop clear.
- R8: `res_valid` is high for exactly one cycle per frame, in the cycle after the edge that accepted byte 37. Bytes after byte 37 do not produce a further result.
- R9: If `in_eof` arrives on a byte before byte 37, the result is given in the cycle after that byte. Every enabled comparison counts as a mismatch, so the result is queue 0 with drop clear.
- R10: A rule write takes effect from the next frame start. A write made while a frame is in progress does not change that frame's result.
- R11: `res_drop` equals bit 30 of the winning rule, and it is reported together with that rule's queue.
- R12: Cycles with `in_valid` low inside a frame do not advance the byte count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Frame byte present |
| in_byte | input | 8 | Frame byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| cfg_we | input | 1 | Rule write strobe |
| cfg_idx | input | $clog2(N_RULES) | Rule index to write |
| cfg_data | input | 32 | Rule word |
| res_valid | output | 1 | Result strobe, one cycle |
| res_queue | output | 4 | Selected queue |
| res_drop | output | 1 | Drop requested |

## Verification
Frames are sent with DS/TC-only, port-only and dual-comparison rules. Matching and near-miss values separate a correct match from a wrong byte offset, swapped port bytes, or an OR in place of the match/mismatch rule. Overlapping rules, a rule with no comparisons enabled but matching values, and a drop rule show the priority order and the drop reporting. Short frames ending just before and exactly at byte 37, frames with idle gaps, long frames and a rule write made mid-frame check the timing of the result pulse, the byte counting and the frame-boundary update of the rules.

// File: rtl/rxscr_pkg.sv
package rxscr_pkg;
   localparam int RULE_W      = 32;
   localparam int QUEUE_W     = 4;
   localparam int DS_OFF      = 15;
   localparam int PORT_HI_OFF = 36;
   localparam int PORT_LO_OFF = 37;
   localparam int CNT_W       = $clog2(PORT_LO_OFF + 2);

   localparam int F_QUEUE_LSB = 0;
   localparam int F_DS_LSB    = 4;
   localparam int F_PORT_LSB  = 12;
   localparam int F_DS_EN     = 28;
   localparam int F_PORT_EN   = 29;
   localparam int F_DROP      = 30;

   typedef logic [RULE_W-1:0] rule_word_t;
endpackage

// File: rtl/rxscr_capture.sv
module rxscr_capture
   import rxscr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [7:0]  in_byte,
   input  logic        in_sof,
   input  logic        in_eof,
   output logic        frame_start,
   output logic        fire,
   output logic        short_frm,
   output logic [7:0]  ds_val,
   output logic [15:0] port_val
);
   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] idx;
   logic [7:0]       ds_q, hi_q;
   logic             acc, at_last;

   assign frame_start = in_valid & in_sof;
   assign acc         = in_valid & (in_sof | busy_q);
   assign idx         = in_sof ? '0 : cnt_q;
   assign at_last     = (idx == CNT_W'(PORT_LO_OFF));
   assign fire        = acc & (at_last | in_eof);
   assign short_frm   = ~at_last;
   assign ds_val      = ds_q;
   assign port_val    = {hi_q, in_byte};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         ds_q   <= '0;
         hi_q   <= '0;
      end else if (acc) begin
         cnt_q  <= idx + 1'b1;
         busy_q <= ~fire;
         if (idx == CNT_W'(DS_OFF))      ds_q <= in_byte;
         if (idx == CNT_W'(PORT_HI_OFF)) hi_q <= in_byte;
      end
   end
endmodule

// File: rtl/rxscr_rule_bank.sv
module rxscr_rule_bank
   import rxscr_pkg::*;
#(
   parameter int N_RULES = 4,
   localparam int IDX_W  = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cfg_we,
   input  logic [IDX_W-1:0]                cfg_idx,
   input  logic [RULE_W-1:0]               cfg_data,
   input  logic                            load,
   output logic [N_RULES-1:0][RULE_W-1:0]  act_words
);
   logic [N_RULES-1:0][RULE_W-1:0] stage_q, act_q;

   for (genvar g = 0; g < N_RULES; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[g] <= '0;
            act_q[g]   <= '0;
         end else begin
            if (cfg_we && cfg_idx == IDX_W'(g)) stage_q[g] <= cfg_data;
            if (load)                           act_q[g]   <= stage_q[g];
         end
      end
   end

   assign act_words = act_q;
endmodule

// File: rtl/rxscr_select.sv
module rxscr_select
   import rxscr_pkg::*;
#(
   parameter int N_RULES = 4
) (
   input  logic [N_RULES-1:0][RULE_W-1:0] act_words,
   input  logic [7:0]                     ds_val,
   input  logic [15:0]                    port_val,
   input  logic                           short_frm,
   output logic                           any_hit,
   output logic [QUEUE_W-1:0]             win_queue,
   output logic                           win_drop
);
   logic [N_RULES-1:0] sel;
   logic [N_RULES-1:0] unused_top;

   for (genvar g = 0; g < N_RULES; g++) begin : g_rule
      rule_word_t w;
      logic ds_en, pt_en, ds_ok, pt_ok, any_ok, any_bad;
      assign w       = act_words[g];
      assign ds_en   = w[F_DS_EN];
      assign pt_en   = w[F_PORT_EN];
      assign ds_ok   = ~short_frm && (w[F_DS_LSB +: 8] == ds_val);
      assign pt_ok   = ~short_frm && (w[F_PORT_LSB +: 16] == port_val);
      assign any_ok  = (ds_en & ds_ok) | (pt_en & pt_ok);
      assign any_bad = (ds_en & ~ds_ok) | (pt_en & ~pt_ok);
      assign sel[g]  = any_ok & ~any_bad;
      assign unused_top[g] = w[RULE_W-1];
   end

   always_comb begin
      any_hit   = 1'b0;
      win_queue = '0;
      win_drop  = 1'b0;
      for (int i = N_RULES - 1; i >= 0; i--) begin
         if (sel[i]) begin
            any_hit   = 1'b1;
            win_queue = act_words[i][F_QUEUE_LSB +: QUEUE_W];
            win_drop  = act_words[i][F_DROP];
         end
      end
   end
endmodule

// File: rtl/rx_screen_classifier.sv
module rx_screen_classifier
   import rxscr_pkg::*;
#(
   parameter int N_RULES = 4,
   localparam int IDX_W  = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [7:0]          in_byte,
   input  logic                in_sof,
   input  logic                in_eof,
   input  logic                cfg_we,
   input  logic [IDX_W-1:0]    cfg_idx,
   input  logic [31:0]         cfg_data,
   output logic                res_valid,
   output logic [QUEUE_W-1:0]  res_queue,
   output logic                res_drop
);
   if (N_RULES < 1 || N_RULES > 16) begin : g_bad_n
      $error("N_RULES must be between 1 and 16");
   end

   logic                           cap_start, cap_fire, cap_short;
   logic [7:0]                     cap_ds;
   logic [15:0]                    cap_port;
   logic [N_RULES-1:0][RULE_W-1:0] act_words;
   logic                           sel_any, sel_drop;
   logic [QUEUE_W-1:0]             sel_queue;

   rxscr_capture i_cap (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_sof(in_sof), .in_eof(in_eof), .frame_start(cap_start),
      .fire(cap_fire), .short_frm(cap_short), .ds_val(cap_ds),
      .port_val(cap_port)
   );

   rxscr_rule_bank #(.N_RULES(N_RULES)) i_bank (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_data(cfg_data), .load(cap_start), .act_words(act_words)
   );

   rxscr_select #(.N_RULES(N_RULES)) i_sel (
      .act_words(act_words), .ds_val(cap_ds), .port_val(cap_port),
      .short_frm(cap_short), .any_hit(sel_any), .win_queue(sel_queue),
      .win_drop(sel_drop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_queue <= '0;
         res_drop  <= 1'b0;
      end else begin
         res_valid <= cap_fire;
         if (cap_fire) begin
            res_queue <= sel_queue;
            res_drop  <= sel_drop;
         end
      end
   end
endmodule

// File: rtl/rxscr_checker.sv
module rxscr_checker
   import rxscr_pkg::*;
#(
   parameter int N_RULES = 4
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           in_valid,
   input logic                           in_sof,
   input logic                           cap_fire,
   input logic                           cap_short,
   input logic                           sel_any,
   input logic [N_RULES-1:0][RULE_W-1:0] act_words,
   input logic                           res_valid,
   input logic [QUEUE_W-1:0]             res_queue,
   input logic                           res_drop
);
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> !res_valid); // R1

   AST_FIRE_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      cap_fire |=> res_valid); // R8

   AST_QUIET_WITHOUT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_fire |=> !res_valid); // R8

   AST_SHORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cap_fire && cap_short |=> res_queue == '0 && !res_drop); // R9

   AST_NOMATCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cap_fire && !sel_any |=> res_queue == '0 && !res_drop); // R7

   AST_RULES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_sof) |=> $stable(act_words)); // R10
endmodule

bind rx_screen_classifier rxscr_checker #(.N_RULES(N_RULES)) i_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
   .cap_fire(cap_fire), .cap_short(cap_short), .sel_any(sel_any),
   .act_words(act_words), .res_valid(res_valid), .res_queue(res_queue),
   .res_drop(res_drop)
);

// File: tb/test_rx_screen_classifier.sv
module test_rx_screen_classifier;
   localparam int CLK_PERIOD = 10;
   localparam int NR = 4;

   typedef struct {
      logic [3:0] q;
      logic       d;
      int         cyc;
      string      tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic [7:0]  in_byte = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_idx = '0;
   logic [31:0] cfg_data = '0;
   logic        res_valid, res_drop;
   logic [3:0]  res_queue;

   int   n_chk = 0, n_bad = 0, cyc = 0;
   exp_t sb[$];
   logic [31:0] pend [NR];
   logic [31:0] act  [NR];

   rx_screen_classifier #(.N_RULES(NR)) i_rx_screen_classifier (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_sof(in_sof), .in_eof(in_eof), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_data(cfg_data), .res_valid(res_valid), .res_queue(res_queue),
      .res_drop(res_drop)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [31:0] mk(input logic [3:0] q, input logic [7:0] ds,
                                      input logic [15:0] pt, input logic ds_en,
                                      input logic pt_en, input logic drop);
      return {1'b0, drop, pt_en, ds_en, pt, ds, q};
   endfunction

   function automatic logic [4:0] model(input logic [7:0] ds, input logic [15:0] pt,
                                        input logic full);
      for (int i = 0; i < NR; i++) begin
         logic de, pe, dok, pok, ok, bad;
         de  = act[i][28];
         pe  = act[i][29];
         dok = full && act[i][11:4] == ds;
         pok = full && act[i][27:12] == pt;
         ok  = (de && dok) || (pe && pok);
         bad = (de && !dok) || (pe && !pok);
         if (ok && !bad) return {act[i][30], act[i][3:0]};
      end
      return 5'd0;
   endfunction

   task automatic check(input bit ok, input string tag, input int act_v, input int exp_v);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
      end
   endtask

   task automatic wr(input int idx, input logic [31:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_data = data;
      pend[idx] = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic send(input logic [7:0] ds, input logic [15:0] pt, input int len,
                       input bit gaps, input string tag,
                       input bit mid_we = 0, input int mid_idx = 0,
                       input logic [31:0] mid_data = '0);
      logic [4:0] e;
      bit full;
      full = (len >= 38);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (i == 0) for (int k = 0; k < NR; k++) act[k] = pend[k];
         in_valid = 1'b1;
         in_sof   = (i == 0);
         in_eof   = (i == len - 1);
         in_byte  = (i == 15) ? ds : (i == 36) ? pt[15:8] :
                    (i == 37) ? pt[7:0] : 8'(8'h40 + i);
         cfg_we   = mid_we && (i == 20);
         cfg_idx  = 2'(mid_idx);
         cfg_data = mid_data;
         if (mid_we && i == 20) pend[mid_idx] = mid_data;
         if (i == 37 || (!full && i == len - 1)) begin
            exp_t x;
            e = model(ds, pt, full);
            x.q = e[3:0]; x.d = e[4]; x.cyc = cyc + 1; x.tag = tag;
            sb.push_back(x);
         end
         if (gaps && (i % 3 == 1)) begin
            @(negedge clk);
            in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; cfg_we = 1'b0;
            in_byte = 8'h2E;
         end
      end
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; cfg_we = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   // Monitor: pops the scoreboard whenever a result appears
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (sb.size() == 0) begin
            check(0, "R8 unexpected result", 1, 0);
         end else begin
            exp_t x;
            x = sb.pop_front();
            check(res_queue == x.q && res_drop == x.d, x.tag,
                  {res_drop, res_queue}, {x.d, x.q});
            check(cyc == x.cyc, {x.tag, " R8 timing"}, cyc, x.cyc);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      for (int k = 0; k < NR; k++) begin pend[k] = '0; act[k] = '0; end
      repeat (3) @(negedge clk);
      check(res_valid == 1'b0, "R1 reset valid", res_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(res_valid == 1'b0, "R1 idle valid", res_valid, 0);

      send(8'h2E, 16'h1234, 40, 0, "R1 R7 unprogrammed");

      wr(0, mk(4'd3, 8'h2E, 16'h0000, 1, 0, 0));
      send(8'h2E, 16'h9999, 40, 0, "R2 R3 ds match");
      send(8'h2F, 16'h9999, 40, 0, "R7 ds near miss");

      wr(0, mk(4'd5, 8'h00, 16'h1234, 0, 1, 0));
      send(8'h11, 16'h1234, 40, 0, "R3 port match");
      send(8'h11, 16'h3412, 40, 0, "R3 port byte order");

      wr(0, mk(4'd6, 8'h10, 16'h0800, 1, 1, 0));
      send(8'h10, 16'h0800, 40, 0, "R4 both match");
      send(8'h10, 16'h0801, 40, 0, "R4 port mismatch");
      send(8'h18, 16'h0800, 40, 0, "R4 ds mismatch");

      wr(0, mk(4'd9, 8'h22, 16'h4444, 0, 0, 1));
      send(8'h22, 16'h4444, 40, 0, "R5 no enables");

      wr(1, mk(4'd1, 8'h22, 16'h0000, 1, 0, 0));
      wr(2, mk(4'd2, 8'h00, 16'h4444, 0, 1, 1));
      send(8'h22, 16'h4444, 40, 0, "R6 lowest wins");
      send(8'h23, 16'h4444, 40, 0, "R11 drop rule");

      send(8'h22, 16'h4444, 30, 0, "R9 short frame");
      send(8'h22, 16'h4444, 37, 0, "R9 ends at byte 36");
      send(8'h22, 16'h4444, 38, 0, "R8 ends at byte 37");
      send(8'h22, 16'h4444, 64, 0, "R8 long frame");
      send(8'h23, 16'h4444, 50, 1, "R12 idle gaps");

      wr(1, 32'h0);
      wr(2, 32'h0);
      send(8'h77, 16'hBEEF, 40, 0, "R10 write mid-frame", 1, 3,
           mk(4'd12, 8'h77, 16'hBEEF, 1, 1, 0));
      send(8'h77, 16'hBEEF, 40, 0, "R10 next frame sees write");
      send(8'h77, 16'hBEEF, 40, 1, "R12 R10 gaps after write");

      repeat (5) @(negedge clk);
      check(sb.size() == 0, "R8 missing results", sb.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule